// File: doc/BRIEF.md
# Coded Bus Clock Prescaler

This block produces three clock-enable strobes for on-chip buses from a single system clock. One is for a high-speed bus and two are for peripheral buses. Each strobe is set by a small prescaler code. The high-speed path reads a 4-bit code and each peripheral path reads a 3-bit code. A path decodes its code into a power-of-two division ratio and raises its enable for exactly one system cycle out of every ratio cycles. Logic on the bus side qualifies its flops with that enable instead of using a gated clock.

The decode is deliberately nonlinear. The whole lower half of each code space means "no division". The high-speed path has no code for divide-by-32, so its ratios jump from 16 to 64. Each path also reports its current ratio as a shift amount, so software or a neighbouring block can compute the bus frequency as the system frequency shifted right by that amount.

A code change never cuts a period short. A path samples its code only when its internal count starts a new period, and the reported shift always describes the period in progress.

Top module: `bus_clk_prescaler`

## Requirements
- R1: High-speed codes 0 through 7 select shift 0. The enable is then high on every cycle.
- R2: High-speed codes 8, 9, 10 and 11 select shifts 1, 2, 3 and 4 (ratios 2, 4, 8, 16).
- R3: High-speed codes 12, 13, 14 and 15 select shifts 6, 7, 8 and 9 (ratios 64, 128, 256, 512). Shift 5 is never produced.
- R4: Peripheral codes 0 through 3 select shift 0. Codes 4, 5, 6 and 7 select shifts 1, 2, 3 and 4.
- R5: For a held code with shift s, the enable is high for one cycle and then low for 2^s - 1 cycles. The bus rate is therefore the system rate shifted right by s.
- R6: A code change between two enable pulses does not alter the current period or the reported shift. The new ratio applies from the next enable pulse.
- R7: While the synchronous reset `rst` is high, all enables are low. In the first cycle after reset is released, every enable is high, and that first period uses the code present in that cycle.
- R8: The three paths run independently. A code on one path never changes the enable or shift of another path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ahb_code | input | 4 | High-speed bus prescaler code |
| apb1_code | input | 3 | First peripheral bus prescaler code |
| apb2_code | input | 3 | Second peripheral bus prescaler code |
| ahb_en | output | 1 | High-speed bus clock enable |
| apb1_en | output | 1 | First peripheral bus clock enable |
| apb2_en | output | 1 | Second peripheral bus clock enable |
| ahb_shift | output | 4 | Shift amount of the high-speed period in progress |
| apb1_shift | output | 4 | Shift amount of the first peripheral period in progress |
| apb2_shift | output | 4 | Shift amount of the second peripheral period in progress |

## Verification
Two functions can meet in one cycle: a code change, and the start of a new period, when the code is sampled. The bench provokes this by switching the code in the middle of a long period, and it checks two things. First, the old ratio keeps both the enable and the reported shift until the boundary. Second, the next pulse arrives exactly 2^s cycles after the previous one. From that boundary on, the new ratio must hold, including the case where divide-by-16 collapses to every-cycle enables. A full sweep of all high-speed codes, run together with rotating peripheral codes, checks that every decode and every pulse spacing matches the value computed in the bench.

// File: rtl/bus_psc_pkg.sv
package bus_psc_pkg;
  localparam int AHB_CODE_W = 4;
  localparam int APB_CODE_W = 3;
  localparam int SHIFT_W    = 4;
  localparam int MAX_SHIFT  = 9;
  localparam int CNT_W      = MAX_SHIFT;

  // High-speed decode: upper half of code space divides; the top quarter skips ratio 32.
  function automatic logic [SHIFT_W-1:0] ahb_shift_of(input logic [AHB_CODE_W-1:0] c);
    logic [SHIFT_W-1:0] s;
    if (!c[3])      s = '0;
    else if (!c[2]) s = SHIFT_W'(c[1:0]) + SHIFT_W'(1);
    else            s = SHIFT_W'(c[1:0]) + SHIFT_W'(6);
    return s;
  endfunction

  // Peripheral decode: upper half of code space divides by 2..16.
  function automatic logic [SHIFT_W-1:0] apb_shift_of(input logic [APB_CODE_W-1:0] c);
    logic [SHIFT_W-1:0] s;
    if (!c[2]) s = '0;
    else       s = SHIFT_W'(c[1:0]) + SHIFT_W'(1);
    return s;
  endfunction

  // Terminal count of a period of length 2^s: s low bits set.
  function automatic logic [CNT_W-1:0] last_count_of(input logic [SHIFT_W-1:0] s);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction
endpackage

// File: rtl/psc_decode.sv
module psc_decode
  import bus_psc_pkg::*;
#(
  parameter bit IS_AHB = 1'b1,
  parameter int CODE_W = AHB_CODE_W
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [SHIFT_W-1:0] shift_o
);
  generate
    if (IS_AHB) begin : g_ahb
      assign shift_o = ahb_shift_of(AHB_CODE_W'(code_i));
    end else begin : g_apb
      assign shift_o = apb_shift_of(APB_CODE_W'(code_i));
    end
  endgenerate
endmodule

// File: rtl/psc_divider.sv
module psc_divider
  import bus_psc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] req_shift_i,
  output logic               en_o,
  output logic               start_o,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [SHIFT_W-1:0] eff_shift;
  logic               at_last;

  // A period starts whenever the count is zero; only then is the request sampled.
  assign start_o   = (cnt_q == '0);
  assign eff_shift = start_o ? req_shift_i : shift_q;
  assign at_last   = (cnt_q == last_count_of(eff_shift));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      cnt_q   <= at_last ? '0 : cnt_q + CNT_W'(1);
      shift_q <= eff_shift;
    end
  end

  assign en_o    = start_o && !rst;
  assign shift_o = eff_shift;
endmodule

// File: rtl/psc_path.sv
module psc_path
  import bus_psc_pkg::*;
#(
  parameter bit IS_AHB = 1'b1,
  parameter int CODE_W = AHB_CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code_i,
  output logic               en_o,
  output logic               start_o,
  output logic [SHIFT_W-1:0] req_shift_o,
  output logic [SHIFT_W-1:0] shift_o
);
  psc_decode #(.IS_AHB(IS_AHB), .CODE_W(CODE_W)) u_dec (
    .code_i  (code_i),
    .shift_o (req_shift_o)
  );

  psc_divider u_div (
    .clk         (clk),
    .rst         (rst),
    .req_shift_i (req_shift_o),
    .en_o        (en_o),
    .start_o     (start_o),
    .shift_o     (shift_o)
  );
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
  import bus_psc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AHB_CODE_W-1:0] ahb_code,
  input  logic [APB_CODE_W-1:0] apb1_code,
  input  logic [APB_CODE_W-1:0] apb2_code,
  output logic                  ahb_en,
  output logic                  apb1_en,
  output logic                  apb2_en,
  output logic [SHIFT_W-1:0]    ahb_shift,
  output logic [SHIFT_W-1:0]    apb1_shift,
  output logic [SHIFT_W-1:0]    apb2_shift
);
  // Named internal events for the checker.
  logic               ahb_start, apb1_start, apb2_start;
  logic [SHIFT_W-1:0] ahb_req_shift, apb1_req_shift, apb2_req_shift;

  psc_path #(.IS_AHB(1'b1), .CODE_W(AHB_CODE_W)) u_ahb (
    .clk (clk), .rst (rst), .code_i (ahb_code),
    .en_o (ahb_en), .start_o (ahb_start),
    .req_shift_o (ahb_req_shift), .shift_o (ahb_shift)
  );

  psc_path #(.IS_AHB(1'b0), .CODE_W(APB_CODE_W)) u_apb1 (
    .clk (clk), .rst (rst), .code_i (apb1_code),
    .en_o (apb1_en), .start_o (apb1_start),
    .req_shift_o (apb1_req_shift), .shift_o (apb1_shift)
  );

  psc_path #(.IS_AHB(1'b0), .CODE_W(APB_CODE_W)) u_apb2 (
    .clk (clk), .rst (rst), .code_i (apb2_code),
    .en_o (apb2_en), .start_o (apb2_start),
    .req_shift_o (apb2_req_shift), .shift_o (apb2_shift)
  );
endmodule

// File: rtl/bus_clk_prescaler_chk.sv
module psc_path_chk
  import bus_psc_pkg::*;
#(
  parameter int LIMIT = MAX_SHIFT
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [SHIFT_W-1:0] shift
);
  logic [15:0]        gap_q;
  logic [SHIFT_W-1:0] last_sh_q;
  logic               seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0; last_sh_q <= '0; seen_q <= 1'b0;
    end else if (en) begin
      gap_q <= 16'd1; last_sh_q <= shift; seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 16'd1;
    end
  end

  assert_shift_range_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(shift) <= LIMIT) && (shift != 4'd5));
  assert_every_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    (en && shift == '0) |=> en);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (en && shift != '0) |=> !en);
  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |-> (shift == $past(shift)));
  assert_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (en && seen_q) |-> (gap_q == (16'd1 << last_sh_q)));
endmodule

module bus_clk_prescaler_chk
  import bus_psc_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [AHB_CODE_W-1:0] ahb_code,
  input logic [APB_CODE_W-1:0] apb1_code,
  input logic [SHIFT_W-1:0]    ahb_req_shift,
  input logic [SHIFT_W-1:0]    apb1_req_shift,
  input logic                  ahb_en,
  input logic                  apb1_en,
  input logic                  apb2_en,
  input logic                  ahb_start
);
  assert_low_half_R1: assert property (@(posedge clk) disable iff (rst)
    (ahb_code < 4'd8) |-> (ahb_req_shift == '0));
  assert_mid_quarter_R2: assert property (@(posedge clk) disable iff (rst)
    (ahb_code >= 4'd8 && ahb_code < 4'd12) |-> (ahb_req_shift == 4'(ahb_code) - 4'd7));
  assert_top_quarter_R3: assert property (@(posedge clk) disable iff (rst)
    (ahb_code >= 4'd12) |-> (ahb_req_shift == 4'(ahb_code) - 4'd6));
  assert_apb_decode_R4: assert property (@(posedge clk) disable iff (rst)
    apb1_req_shift == ((apb1_code >= 3'd4) ? 4'(apb1_code) - 4'd3 : 4'd0));
  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |-> !(ahb_en || apb1_en || apb2_en));
  assert_first_pulse_R7: assert property (@(posedge clk)
    $fell(rst) |-> (ahb_en && apb1_en && apb2_en));
  assert_start_is_en_R8: assert property (@(posedge clk) disable iff (rst)
    ahb_start == ahb_en);
endmodule

bind bus_clk_prescaler psc_path_chk #(.LIMIT(9)) u_chk_ahb (
  .clk (clk), .rst (rst), .en (ahb_en), .shift (ahb_shift));
bind bus_clk_prescaler psc_path_chk #(.LIMIT(4)) u_chk_apb1 (
  .clk (clk), .rst (rst), .en (apb1_en), .shift (apb1_shift));
bind bus_clk_prescaler psc_path_chk #(.LIMIT(4)) u_chk_apb2 (
  .clk (clk), .rst (rst), .en (apb2_en), .shift (apb2_shift));
bind bus_clk_prescaler bus_clk_prescaler_chk u_chk_top (
  .clk (clk), .rst (rst), .ahb_code (ahb_code), .apb1_code (apb1_code),
  .ahb_req_shift (ahb_req_shift), .apb1_req_shift (apb1_req_shift),
  .ahb_en (ahb_en), .apb1_en (apb1_en), .apb2_en (apb2_en),
  .ahb_start (ahb_start));

// File: tb/bus_clk_prescaler_bench.sv
`timescale 1ns/1ps
module bus_clk_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ahb_code = '0;
  logic [2:0] apb1_code = '0, apb2_code = '0;
  logic       ahb_en, apb1_en, apb2_en;
  logic [3:0] ahb_shift, apb1_shift, apb2_shift;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bus_clk_prescaler u_bus_clk_prescaler (
    .clk (clk), .rst (rst), .ahb_code (ahb_code), .apb1_code (apb1_code),
    .apb2_code (apb2_code), .ahb_en (ahb_en), .apb1_en (apb1_en),
    .apb2_en (apb2_en), .ahb_shift (ahb_shift), .apb1_shift (apb1_shift),
    .apb2_shift (apb2_shift));

  // Expected shifts restated as ratio exponents.
  function automatic int exp_ahb(input int c);
    int r;
    if (c < 8) return 0;
    r = 2 ** (c - 7);
    if (c >= 12) r = r * 2;
    return $clog2(r);
  endfunction
  function automatic int exp_apb(input int c);
    return (c < 4) ? 0 : c - 3;
  endfunction
  function automatic bit pulse_at(input int t, input int s);
    return (t % (1 << s)) == 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reset held over a clock edge, released at a falling edge: cycle 0 begins.
  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7", "ahb_en in reset", int'(ahb_en), 0);
    check("R7", "apb1_en in reset", int'(apb1_en), 0);
    check("R7", "apb2_en in reset", int'(apb2_en), 0);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    // Sweep: every high-speed code, rotating peripheral codes.
    for (int c = 0; c < 16; c++) begin
      int sa, s1, s2;
      ahb_code  = 4'(c);
      apb1_code = 3'(c % 8);
      apb2_code = 3'((c + 3) % 8);
      sa = exp_ahb(c); s1 = exp_apb(c % 8); s2 = exp_apb((c + 3) % 8);
      do_reset();
      for (int t = 0; t < (1 << sa) * 2 + 2; t++) begin
        string ra;
        ra = (c < 8) ? "R1" : (c < 12) ? "R2" : "R3";
        check(ra, "ahb_shift", int'(ahb_shift), sa);
        check("R5", "ahb_en", int'(ahb_en), int'(pulse_at(t, sa)));
        check("R4", "apb1_shift", int'(apb1_shift), s1);
        check("R8", "apb1_en", int'(apb1_en), int'(pulse_at(t, s1)));
        check("R4", "apb2_shift", int'(apb2_shift), s2);
        check("R8", "apb2_en", int'(apb2_en), int'(pulse_at(t, s2)));
        @(negedge clk); #1;
      end
    end

    // Mid-period code change on two paths; third held.
    ahb_code = 4'd15; apb1_code = 3'd7; apb2_code = 3'd5;
    do_reset();
    for (int t = 0; t < 521; t++) begin
      if (t == 10) ahb_code  = 4'd8;
      if (t == 5)  apb1_code = 3'd0;
      #0;
      check("R6", "ahb_shift", int'(ahb_shift), (t < 512) ? 9 : 1);
      check("R6", "ahb_en", int'(ahb_en),
            int'(t == 0 || (t >= 512 && (t % 2) == 0)));
      check("R6", "apb1_shift", int'(apb1_shift), (t < 16) ? 4 : 0);
      check("R6", "apb1_en", int'(apb1_en), int'(t == 0 || t >= 16));
      check("R8", "apb2_en", int'(apb2_en), int'(pulse_at(t, 2)));
      @(negedge clk); #1;
    end

    // First period after reset follows the code present at release.
    ahb_code = 4'd9;
    do_reset();
    check("R7", "ahb_en first cycle", int'(ahb_en), 1);
    check("R7", "ahb_shift first cycle", int'(ahb_shift), 2);
    @(negedge clk); #1;
    check("R7", "ahb_en second cycle", int'(ahb_en), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule